// File: doc/BRIEF.md
# Coprocessor Control and Interrupt Register

This block is a single 16-bit control and status word that a host processor uses to supervise an attached audio coprocessor. It collects interrupt events from three sources: the coprocessor itself, the auxiliary-memory DMA engine and the audio interface. Each source has a pending flag and an enable bit. The host clears a pending flag by writing 1 to it. The block merges the enabled pending flags into one interrupt line toward the host.

The same word also drives three controls toward the coprocessor:
- a level-held stall (halt) control;
- a host-to-coprocessor interrupt request;
- a self-clearing reset strobe.

The word is reached through a plain select/write/address port. It sits at byte offset 0x0A inside a 0x200-byte window and is accessed as one 16-bit value.

Top module: `copro_ctrl_reg`

## Requirements
- R1: While `rst_n` is low, every stored bit is 0. As a result `host_irq`, `halt`, `copro_irq_req` and `copro_reset` are 0 and a read of the word returns 0x0000.
- R2: A 1 on `ev_aud`, `ev_dma` or `ev_copro` in a clock cycle sets that source's pending flag. From the next cycle the flag reads 1: audio at bit 3, DMA at bit 5, coprocessor at bit 7.
- R3: A write with 1 in a pending-flag position (bit 3, 5 or 7) clears that flag. A write with 0 there leaves the flag unchanged.
- R4: Enable bits sit at bit 4 (audio), bit 6 (DMA) and bit 8 (coprocessor), and take the written value on every write. `host_irq` is 1 exactly when at least one source has both its pending flag and its enable bit set.
- R5: Bit 2 is a read/write halt bit. `halt` equals its stored value and changes in the cycle after the write.
- R6: A write with bit 0 set makes `copro_reset` high for exactly the following cycle. Bit 0 always reads back as 0.
- R7: Bit 1 is a read/write request bit. `copro_irq_req` equals its stored value and changes in the cycle after the write.
- R8: If an event arrives in the same cycle as a write-1 clear of its flag, the event wins and the flag stays set.
- R9: Bits 15 to 9 always read as 0. A read at any offset other than 0x0A returns 0x0000.
- R10: The word is written only when `reg_sel` and `reg_wr` are both 1 and `reg_addr` equals 0x0A. Any other write leaves all state and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 9 | Byte offset within the window |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational, 0 when not read) |
| ev_aud | input | 1 | Audio interface event pulse |
| ev_dma | input | 1 | Auxiliary-memory DMA event pulse |
| ev_copro | input | 1 | Coprocessor event pulse |
| host_irq | output | 1 | Merged enabled interrupt to the host |
| halt | output | 1 | Coprocessor stall control |
| copro_reset | output | 1 | One-cycle coprocessor reset strobe |
| copro_irq_req | output | 1 | Interrupt request toward the coprocessor |

## Verification
The two functions that collide are a source event pulse and a host write that clears the same pending flag with a 1. The bench provokes this collision twice. First, a directed write of 1 to the audio flag is issued in the very cycle its event fires. Second, random stimulus drives events and full-word writes at the same moments. The collision is judged by reading the word back and watching `host_irq`: the flag must remain set, and the reference model applies event-over-clear priority on every clock.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 9;
  localparam int NSRC     = 3;
  localparam int BIT_RST  = 0;
  localparam int BIT_REQ  = 1;
  localparam int BIT_HALT = 2;
  localparam int BIT_SRC0 = 3;
  localparam int USED_W   = BIT_SRC0 + 2 * NSRC;

  // source index: 0 audio, 1 DMA, 2 coprocessor
  function automatic int stat_pos(input int idx);
    return BIT_SRC0 + 2 * idx;
  endfunction

  function automatic int mask_pos(input int idx);
    return BIT_SRC0 + 2 * idx + 1;
  endfunction

  function automatic logic any_enabled(input logic [NSRC-1:0] st,
                                       input logic [NSRC-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/ccr_src_bit.sv
module ccr_src_bit #(
  parameter int DATA_W = 16,
  parameter int ST_POS = 3,
  parameter int MK_POS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev,
  output logic              stat,
  output logic              mask
);
  logic clr_hit;
  assign clr_hit = wr_hit & wdata[ST_POS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= 1'b0;
      mask <= 1'b0;
    end else begin
      // event beats a simultaneous clear
      if (ev)           stat <= 1'b1;
      else if (clr_hit) stat <= 1'b0;
      if (wr_hit)       mask <= wdata[MK_POS];
    end
  end

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> stat);
  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && clr_hit) |=> stat);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !ev) |=> !stat);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hit && !ev) |=> $stable(stat));
  p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (mask == $past(wdata[MK_POS])));
endmodule

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  output logic          halt_q,
  output logic          req_q,
  output logic          rst_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q    <= 1'b0;
      req_q     <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= wr_hit & wdata[BIT_RST];
      if (wr_hit) begin
        halt_q <= wdata[BIT_HALT];
        req_q  <= wdata[BIT_REQ];
      end
    end
  end

  p_pulse_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(wr_hit && wdata[BIT_RST]));
  p_pulse_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> !rst_pulse);
  p_halt_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (halt_q == $past(wdata[BIT_HALT])));
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(req_q));
endmodule

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int             AW  = ADDR_W,
  parameter int             DW  = DATA_W,
  parameter logic [AW-1:0]  OFS = 'h0A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] stat,
  input  logic [NSRC-1:0] mask,
  input  logic            halt_q,
  input  logic            req_q,
  output logic            wr_hit,
  output logic [DW-1:0]   rdata
);
  logic          addr_hit;
  logic          rd_hit;
  logic [DW-1:0] word;

  assign addr_hit = sel & (addr == OFS);
  assign wr_hit   = addr_hit & wr;
  assign rd_hit   = addr_hit & ~wr;

  always_comb begin
    word           = '0;
    word[BIT_REQ]  = req_q;
    word[BIT_HALT] = halt_q;
    for (int i = 0; i < NSRC; i++) begin
      word[stat_pos(i)] = stat[i];
      word[mask_pos(i)] = mask[i];
    end
    rdata = rd_hit ? word : '0;
  end

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:USED_W] == '0);
  p_rst_bit_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[BIT_RST] == 1'b0);
  p_no_read_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rdata == '0));
endmodule

// File: rtl/copro_ctrl_reg.sv
module copro_ctrl_reg
  import ccr_pkg::*;
#(
  parameter int                 AW  = ADDR_W,
  parameter int                 DW  = DATA_W,
  parameter logic [ADDR_W-1:0]  OFS = 9'h00A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_aud,
  input  logic          ev_dma,
  input  logic          ev_copro,
  output logic          host_irq,
  output logic          halt,
  output logic          copro_reset,
  output logic          copro_irq_req
);
  logic            wr_hit;
  logic [NSRC-1:0] ev_vec;
  logic [NSRC-1:0] stat;
  logic [NSRC-1:0] mask;
  logic            halt_q;
  logic            req_q;
  logic            rst_pulse;

  assign ev_vec = {ev_copro, ev_dma, ev_aud};

  ccr_decode #(.AW(AW), .DW(DW), .OFS(OFS[AW-1:0])) u_dec (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .addr(reg_addr),
    .stat(stat), .mask(mask), .halt_q(halt_q), .req_q(req_q),
    .wr_hit(wr_hit), .rdata(reg_rdata)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ccr_src_bit #(.DATA_W(DW), .ST_POS(stat_pos(g)), .MK_POS(mask_pos(g))) u_src (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(reg_wdata),
      .ev(ev_vec[g]), .stat(stat[g]), .mask(mask[g])
    );
  end

  ccr_ctrl #(.DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(reg_wdata),
    .halt_q(halt_q), .req_q(req_q), .rst_pulse(rst_pulse)
  );

  assign host_irq      = any_enabled(stat, mask);
  assign halt          = halt_q;
  assign copro_reset   = rst_pulse;
  assign copro_irq_req = req_q;

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!host_irq && !halt && !copro_reset && !copro_irq_req));
  p_irq_needs_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (stat != '0));
  p_foreign_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(mask) && $stable(halt_q) && !rst_pulse));
endmodule

// File: tb/test_copro_ctrl_reg.sv
module test_copro_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ev_aud = 1'b0, ev_dma = 1'b0, ev_copro = 1'b0;
  logic        host_irq, halt, copro_reset, copro_irq_req;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // reference state, source order: 0 audio, 1 DMA, 2 coprocessor
  bit m_st[3] = '{0, 0, 0};
  bit m_mk[3] = '{0, 0, 0};
  bit m_halt = 0, m_req = 0, m_rp = 0;

  copro_ctrl_reg i_copro_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_aud(ev_aud), .ev_dma(ev_dma), .ev_copro(ev_copro),
    .host_irq(host_irq), .halt(halt), .copro_reset(copro_reset),
    .copro_irq_req(copro_irq_req)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    bit hit;
    bit evs[3];
    evs = '{ev_aud, ev_dma, ev_copro};
    hit = reg_sel && reg_wr && (reg_addr == 9'd10);
    if (!rst_n) begin
      m_st = '{0, 0, 0}; m_mk = '{0, 0, 0};
      m_halt = 0; m_req = 0; m_rp = 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (evs[i]) m_st[i] = 1;
        else if (hit && reg_wdata[3 + 2 * i]) m_st[i] = 0;
        if (hit) m_mk[i] = reg_wdata[4 + 2 * i];
      end
      m_rp = hit && reg_wdata[0];
      if (hit) begin
        m_halt = reg_wdata[2];
        m_req  = reg_wdata[1];
      end
    end
  end

  function automatic int model_word();
    int w = 0;
    w |= int'(m_req) << 1;
    w |= int'(m_halt) << 2;
    for (int i = 0; i < 3; i++) begin
      w |= int'(m_st[i]) << (3 + 2 * i);
      w |= int'(m_mk[i]) << (4 + 2 * i);
    end
    return w;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_rd;
    bit any;
    any = 0;
    for (int i = 0; i < 3; i++) any |= m_st[i] & m_mk[i];
    exp_rd = (reg_sel && !reg_wr && reg_addr == 9'd10) ? model_word() : 0;
    chk("R9 rdata", int'(reg_rdata), exp_rd);
    chk("R4 host_irq", int'(host_irq), int'(any));
    chk("R5 halt", int'(halt), int'(m_halt));
    chk("R6 copro_reset", int'(copro_reset), int'(m_rp));
    chk("R7 copro_irq_req", int'(copro_irq_req), int'(m_req));
  endtask

  task automatic cyc(input bit s, input bit w, input int a, input int d, input bit [2:0] ev);
    @(negedge clk);
    compare_all();
    reg_sel = s; reg_wr = w; reg_addr = 9'(a); reg_wdata = 16'(d);
    {ev_copro, ev_dma, ev_aud} = ev;
  endtask

  task automatic wr(input int d, input bit [2:0] ev = 3'b000);
    cyc(1, 1, 10, d, ev);
  endtask

  task automatic rd_chk(input string tag, input int exp);
    cyc(1, 0, 10, 0, 3'b000);
    #1 chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 3'b000);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    rd_chk("R1 reset read", 0);
    idle();
    #1 chk("R1 reset outputs", int'({host_irq, halt, copro_reset, copro_irq_req}), 0);
    @(negedge clk) rst_n = 1'b1;
    // R2: event sets audio flag, disabled so no irq
    cyc(0, 0, 0, 0, 3'b001);
    rd_chk("R2 audio flag", 16'h0008);
    chk("R4 masked off", int'(host_irq), 0);
    // R4: enable audio
    wr(16'h0010);
    rd_chk("R4 mask read", 16'h0018);
    chk("R4 irq on", int'(host_irq), 1);
    // R3: writing 0 keeps, writing 1 clears
    wr(16'h0010);
    rd_chk("R3 write0 keeps", 16'h0018);
    wr(16'h0018);
    rd_chk("R3 write1 clears", 16'h0010);
    chk("R3 irq off", int'(host_irq), 0);
    // R8: event with clear in same cycle
    wr(16'h0018, 3'b001);
    rd_chk("R8 event wins", 16'h0018);
    chk("R8 irq held", int'(host_irq), 1);
    // R5: halt
    wr(16'h0004);
    idle();
    #1 chk("R5 halt high", int'(halt), 1);
    rd_chk("R5 halt read", 16'h000C);
    // R6: reset strobe
    wr(16'h0005);
    idle();
    #1 chk("R6 pulse high", int'(copro_reset), 1);
    idle();
    #1 chk("R6 pulse gone", int'(copro_reset), 0);
    rd_chk("R6 bit0 reads 0", 16'h000C);
    // R7: request bit
    wr(16'h0002);
    idle();
    #1 chk("R7 req high", int'(copro_irq_req), 1);
    chk("R5 halt released", int'(halt), 0);
    rd_chk("R7 req read", 16'h000A);
    // R10: writes elsewhere or without select are ignored
    cyc(1, 1, 8, 16'hFFFF, 3'b000);
    cyc(0, 1, 10, 16'hFFFF, 3'b000);
    idle();
    #1 chk("R10 no pulse", int'(copro_reset), 0);
    rd_chk("R10 unchanged", 16'h000A);
    // R9: upper bits read 0, other offsets read 0
    wr(16'hFFFF);
    rd_chk("R9 upper zero", 16'h0156);
    cyc(1, 0, 12, 0, 3'b000);
    #1 chk("R9 other offset", int'(reg_rdata), 0);
    cyc(0, 0, 0, 0, 3'b110);
    rd_chk("R2 dma and copro flags", 16'h01F6);
    // random phase, model compared every clock
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom;
      cyc(r[0] | r[1], r[2], (r[5:3] == 0) ? 12 : 10, $urandom & 16'hFFFF,
          {r[8] & r[9], r[10] & r[11], r[12] & r[13]});
    end
    idle();
    idle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule